// File: doc/BRIEF.md
# Trigger-Selectable Interrupt Source Bank

This block gathers up to 32 asynchronous interrupt lines. It turns each line into a pending condition according to a trigger mode that software picks per source. The modes are rising edge, falling edge, either edge, active-high level or active-low level. Every line first passes through a two-flop synchroniser. Edges are then captured in two separate per-source latches, one for rising events and one for falling events, and a captured event stays there until software clears it.

Every source has three more control bits: a mask enable, a wake enable and an output-select bit. The output-select bit routes the source to one of two request outputs. Each control field is reached through a pair of addresses, one that sets bits and one that clears them. Software can therefore change one source without a read-modify-write. The controls, both capture latches and the synchronised input levels can all be read back over the same single-cycle register bus.

Top module: `irq_trigger_bank`

## Requirements
- R1: The six control fields cfg0, cfg1, cfg2, mask, wake and assign (field index k = 0..5 in that order) are written at address 2k to set and at 2k+1 to clear. Ones in the write data set or clear the matching source bits, and zero bits leave them unchanged. Reading address 2k returns the field, and reading a clear address returns zero.
- R2: The trigger code is {cfg2,cfg1,cfg0}. Code 001 captures rising edges, 010 captures falling edges and 011 captures both. A rising edge of the synchronised input sets the source's bit in the rise latch, read at address 12. A falling edge sets its bit in the fall latch, read at address 14. Only the edge kinds that the code enables are captured.
- R3: A captured latch bit stays set after the input returns to its idle level. It is cleared only by writing a one at its clear address, which is 13 for the rise latch and 15 for the fall latch.
- R4: Code 101 makes the source pending while its synchronised input is high. Code 110 makes it pending while the input is low. Neither level code sets a latch.
- R5: Codes 000, 100 and 111 make the source never pending and never set a latch, whatever the input does.
- R6: A source raises a request only while its mask bit is set. An edge that arrives while the source is masked is still captured. Setting the mask later raises the request.
- R7: A pending, unmasked source with assign = 1 drives irq_req0. With assign = 0 it drives irq_req1.
- R8: wake_req is high while any source is pending with its wake bit set, independent of the mask.
- R9: Address 16 reads the synchronised input levels. Writes to addresses 12, 14 and 16 have no effect.
- R10: Reset clears every control bit and both latches, so all outputs are low and every readable address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Asynchronous interrupt lines, one per source |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Register address, for both read and write |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_req0 | output | 1 | Request from sources with assign = 1 |
| irq_req1 | output | 1 | Request from sources with assign = 0 |
| wake_req | output | 1 | Wake request from wake-enabled pending sources |

## Verification
Each trigger code is driven on its own source with a full input cycle: low to high, then back to low. This tells apart which latch captures which edge and whether the request persists after the input has returned. The level codes are held at both polarities, which shows that the request follows the input with no memory. The reserved codes receive the same pulses and must stay silent. A pulse that arrives while the source is masked, followed by a later unmask and a wake enable, separates latching from gating and mask from wake. The set and clear addresses are driven with overlapping bit patterns, which shows that zero bits in the write data are left alone.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_AW = 5;
    localparam int N_CTL  = 6;

    // Field index, shifted left by one, gives the set address; +1 is the clear address
    typedef enum logic [2:0] {
        FLD_CFG0   = 3'd0,
        FLD_CFG1   = 3'd1,
        FLD_CFG2   = 3'd2,
        FLD_MASK   = 3'd3,
        FLD_WAKE   = 3'd4,
        FLD_ASSIGN = 3'd5,
        FLD_RISE   = 3'd6,
        FLD_FALL   = 3'd7
    } field_e;

    localparam logic [REG_AW-1:0] ADDR_LEVEL = 5'd16;

    typedef struct packed {
        logic rise_en;
        logic fall_en;
        logic lvl_en;
        logic lvl_inv;
    } trig_sel_t;

    function automatic trig_sel_t decode_trig(input logic [2:0] code);
        trig_sel_t s;
        s = '0;
        case (code)
            3'b001: s.rise_en = 1'b1;
            3'b010: s.fall_en = 1'b1;
            3'b011: begin s.rise_en = 1'b1; s.fall_en = 1'b1; end
            3'b101: s.lvl_en = 1'b1;
            3'b110: begin s.lvl_en = 1'b1; s.lvl_inv = 1'b1; end
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic [REG_AW-1:0] clr_addr(input field_e f);
        return {1'b0, f, 1'b1};
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    logic [N-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= raw_in;
            lvl    <= meta_q;
            prev   <= lvl;
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [REG_AW-1:0]          bus_addr,
    input  logic [N-1:0]               bus_wdata,
    output logic [N_CTL-1:0][N-1:0]    ctl_q,
    output logic [N-1:0]               rise_clr,
    output logic [N-1:0]               fall_clr
);
    logic       in_map;
    logic       is_clr;
    logic [2:0] fld;

    assign in_map = bus_wr && !bus_addr[REG_AW-1];
    assign is_clr = bus_addr[0];
    assign fld    = bus_addr[3:1];

    for (genvar f = 0; f < N_CTL; f++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[f] <= '0;
            end else if (in_map && fld == 3'(f)) begin
                if (is_clr)
                    ctl_q[f] <= ctl_q[f] & ~bus_wdata;
                else
                    ctl_q[f] <= ctl_q[f] | bus_wdata;
            end
        end
    end

    assign rise_clr = (bus_wr && bus_addr == clr_addr(FLD_RISE)) ? bus_wdata : '0;
    assign fall_clr = (bus_wr && bus_addr == clr_addr(FLD_FALL)) ? bus_wdata : '0;
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] cfg0,
    input  logic [N-1:0] cfg1,
    input  logic [N-1:0] cfg2,
    input  logic [N-1:0] rise_clr,
    input  logic [N-1:0] fall_clr,
    output logic [N-1:0] rise_q,
    output logic [N-1:0] fall_q,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_src
        trig_sel_t sel;
        logic      up_edge;
        logic      dn_edge;

        assign sel     = decode_trig({cfg2[i], cfg1[i], cfg0[i]});
        assign up_edge = lvl[i] & ~prev[i];
        assign dn_edge = ~lvl[i] & prev[i];

        // A fresh edge wins over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst) begin
                rise_q[i] <= 1'b0;
                fall_q[i] <= 1'b0;
            end else begin
                if (sel.rise_en && up_edge)
                    rise_q[i] <= 1'b1;
                else if (rise_clr[i])
                    rise_q[i] <= 1'b0;
                if (sel.fall_en && dn_edge)
                    fall_q[i] <= 1'b1;
                else if (fall_clr[i])
                    fall_q[i] <= 1'b0;
            end
        end

        assign pend[i] = (sel.rise_en & rise_q[i])
                       | (sel.fall_en & fall_q[i])
                       | (sel.lvl_en  & (lvl[i] ^ sel.lvl_inv));
    end
endmodule

// File: rtl/irq_trigger_bank.sv
module irq_trigger_bank
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_req0,
    output logic               irq_req1,
    output logic               wake_req
);
    logic [N_CTL-1:0][NUM_SRC-1:0] ctl_q;
    logic [NUM_SRC-1:0] lvl, prev;
    logic [NUM_SRC-1:0] rise_clr, fall_clr;
    logic [NUM_SRC-1:0] rise_q, fall_q, pend;
    logic [NUM_SRC-1:0] live;

    irqc_sync #(.N(NUM_SRC)) u_sync (
        .clk(clk), .rst(rst), .raw_in(src_in), .lvl(lvl), .prev(prev)
    );

    irqc_regs #(.N(NUM_SRC)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctl_q(ctl_q),
        .rise_clr(rise_clr), .fall_clr(fall_clr)
    );

    irqc_detect #(.N(NUM_SRC)) u_detect (
        .clk(clk), .rst(rst), .lvl(lvl), .prev(prev),
        .cfg0(ctl_q[FLD_CFG0]), .cfg1(ctl_q[FLD_CFG1]), .cfg2(ctl_q[FLD_CFG2]),
        .rise_clr(rise_clr), .fall_clr(fall_clr),
        .rise_q(rise_q), .fall_q(fall_q), .pend(pend)
    );

    assign live     = pend & ctl_q[FLD_MASK];
    assign irq_req0 = |(live & ctl_q[FLD_ASSIGN]);
    assign irq_req1 = |(live & ~ctl_q[FLD_ASSIGN]);
    assign wake_req = |(pend & ctl_q[FLD_WAKE]);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_LEVEL) begin
            bus_rdata = lvl;
        end else if (!bus_addr[REG_AW-1] && !bus_addr[0]) begin
            case (field_e'(bus_addr[3:1]))
                FLD_CFG0:   bus_rdata = ctl_q[FLD_CFG0];
                FLD_CFG1:   bus_rdata = ctl_q[FLD_CFG1];
                FLD_CFG2:   bus_rdata = ctl_q[FLD_CFG2];
                FLD_MASK:   bus_rdata = ctl_q[FLD_MASK];
                FLD_WAKE:   bus_rdata = ctl_q[FLD_WAKE];
                FLD_ASSIGN: bus_rdata = ctl_q[FLD_ASSIGN];
                FLD_RISE:   bus_rdata = rise_q;
                FLD_FALL:   bus_rdata = fall_q;
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_wr,
    input logic [REG_AW-1:0]       bus_addr,
    input logic [N-1:0]            bus_wdata,
    input logic [N_CTL-1:0][N-1:0] ctl_q,
    input logic [N-1:0]            rise_q,
    input logic [N-1:0]            fall_q,
    input logic [N-1:0]            lvl,
    input logic [N-1:0]            prev,
    input logic                    irq_req0,
    input logic                    irq_req1
);
    logic [N-1:0] rclr_w;
    assign rclr_w = (bus_wr && bus_addr == 5'd13) ? bus_wdata : '0;

    AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'd6) |=> ((ctl_q[3] & $past(bus_wdata)) == $past(bus_wdata))); // R1

    AST_MASK_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'd7) |=> ((ctl_q[3] & $past(bus_wdata)) == '0)); // R1

    AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_q & ~$past(rise_q) & ~($past(lvl) & ~$past(prev))) == '0)); // R2

    AST_FALL_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fall_q & ~$past(fall_q) & ~(~$past(lvl) & $past(prev))) == '0)); // R2

    AST_RISE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(rise_q) & ~$past(rclr_w) & ~rise_q) == '0)); // R3

    AST_REQ0_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_req0 |-> ((ctl_q[3] & ctl_q[5]) != '0)); // R6

    AST_REQ1_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_req1 |-> ((ctl_q[3] & ~ctl_q[5]) != '0)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ctl_q == '0 && rise_q == '0 && fall_q == '0)); // R10
endmodule

bind irq_trigger_bank irqc_checker #(.N(NUM_SRC)) u_irqc_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctl_q(ctl_q), .rise_q(rise_q), .fall_q(fall_q),
    .lvl(lvl), .prev(prev), .irq_req0(irq_req0), .irq_req1(irq_req1)
);

// File: tb/test_irq_trigger_bank.sv
module test_irq_trigger_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req0, irq_req1, wake_req;

    irq_trigger_bank #(.NUM_SRC(32)) i_irq_trigger_bank (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req0(irq_req0), .irq_req1(irq_req1), .wake_req(wake_req)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [4:0]  addr;
        logic [31:0] rd;
        logic [2:0]  outs;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [2:0] got;
            it  = sb_q.pop_front();
            got = {irq_req0, irq_req1, wake_req};
            n_chk++;
            if (bus_rdata !== it.rd || got !== it.outs) begin
                n_fail++;
                $display("FAIL %s addr=%0d rdata=%h exp=%h outs=%b exp=%b",
                         it.req, it.addr, bus_rdata, it.rd, got, it.outs);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_st(input logic [4:0] a, input logic [31:0] rd,
                             input logic [2:0] outs, input string req);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.addr = a; it.rd = rd; it.outs = outs; it.req = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic drive_src(input int i, input logic v);
        @(posedge clk); #1;
        src_in[i] = v;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;

        // R10: everything clear after reset
        for (int a = 0; a <= 16; a++) expect_st(5'(a), 32'h0, 3'b000, "R10");

        // R1: set/clear with overlapping patterns
        wr(6, 32'hF0F0_0000);
        wr(6, 32'h0000_000F);
        expect_st(6, 32'hF0F0_000F, 3'b000, "R1");
        expect_st(7, 32'h0, 3'b000, "R1");
        wr(7, 32'hF000_0001);
        expect_st(6, 32'h00F0_000E, 3'b000, "R1");
        wr(7, 32'hFFFF_FFFF);
        expect_st(6, 32'h0, 3'b000, "R1");
        wr(10, 32'h1);
        expect_st(10, 32'h1, 3'b000, "R1");

        // R2/R3/R7: source 0 rising, routed to irq_req0
        wr(0, 32'h1);
        wr(6, 32'h1);
        expect_st(0, 32'h1, 3'b000, "R1");
        drive_src(0, 1'b1);
        expect_st(12, 32'h1, 3'b100, "R2");
        drive_src(0, 1'b0);
        expect_st(12, 32'h1, 3'b100, "R3");
        expect_st(14, 32'h0, 3'b100, "R2");
        wr(12, 32'hFFFF_FFFF);
        expect_st(12, 32'h1, 3'b100, "R9");
        wr(13, 32'h1);
        expect_st(12, 32'h0, 3'b000, "R3");
        wr(7, 32'h1);

        // R2/R7: source 1 falling, routed to irq_req1
        wr(2, 32'h2);
        wr(6, 32'h2);
        drive_src(1, 1'b1);
        expect_st(14, 32'h0, 3'b000, "R2");
        expect_st(12, 32'h0, 3'b000, "R2");
        drive_src(1, 1'b0);
        expect_st(14, 32'h2, 3'b010, "R7");
        wr(15, 32'h2);
        expect_st(14, 32'h0, 3'b000, "R3");
        wr(7, 32'h2);

        // R2: source 2 both edges
        wr(0, 32'h4);
        wr(2, 32'h4);
        wr(6, 32'h4);
        drive_src(2, 1'b1);
        expect_st(12, 32'h4, 3'b010, "R2");
        wr(13, 32'h4);
        expect_st(12, 32'h0, 3'b000, "R3");
        drive_src(2, 1'b0);
        expect_st(14, 32'h4, 3'b010, "R2");
        wr(15, 32'h4);
        wr(7, 32'h4);
        expect_st(14, 32'h0, 3'b000, "R3");

        // R4: source 3 active-high level
        wr(4, 32'h8);
        wr(0, 32'h8);
        wr(6, 32'h8);
        expect_st(16, 32'h0, 3'b000, "R4");
        drive_src(3, 1'b1);
        expect_st(16, 32'h8, 3'b010, "R9");
        expect_st(12, 32'h0, 3'b010, "R4");
        drive_src(3, 1'b0);
        expect_st(16, 32'h0, 3'b000, "R4");
        wr(7, 32'h8);

        // R4: source 4 active-low level
        wr(4, 32'h10);
        wr(2, 32'h10);
        wr(6, 32'h10);
        expect_st(16, 32'h0, 3'b010, "R4");
        drive_src(4, 1'b1);
        expect_st(16, 32'h10, 3'b000, "R4");
        drive_src(4, 1'b0);
        expect_st(14, 32'h0, 3'b010, "R4");
        wr(7, 32'h10);
        expect_st(6, 32'h0, 3'b000, "R4");

        // R6/R8: source 5 captured while masked, then unmasked, then wake
        wr(0, 32'h20);
        wr(10, 32'h20);
        drive_src(5, 1'b1);
        expect_st(12, 32'h20, 3'b000, "R6");
        wr(6, 32'h20);
        expect_st(12, 32'h20, 3'b100, "R6");
        wr(8, 32'h20);
        expect_st(8, 32'h20, 3'b101, "R8");
        wr(7, 32'h20);
        expect_st(12, 32'h20, 3'b001, "R8");
        wr(13, 32'h20);
        expect_st(12, 32'h0, 3'b000, "R8");
        drive_src(5, 1'b0);
        wr(9, 32'h20);

        // R5: reserved codes 100 and 111, and code 000
        wr(4, 32'h40);
        wr(6, 32'h40);
        wr(8, 32'h40);
        drive_src(6, 1'b1);
        expect_st(12, 32'h0, 3'b000, "R5");
        drive_src(6, 1'b0);
        expect_st(14, 32'h0, 3'b000, "R5");
        wr(0, 32'h40);
        wr(2, 32'h40);
        drive_src(6, 1'b1);
        expect_st(12, 32'h0, 3'b000, "R5");
        expect_st(16, 32'h40, 3'b000, "R5");
        drive_src(6, 1'b0);
        expect_st(14, 32'h0, 3'b000, "R5");
        wr(6, 32'h80);
        drive_src(7, 1'b1);
        expect_st(12, 32'h0, 3'b000, "R5");
        drive_src(7, 1'b0);
        expect_st(14, 32'h0, 3'b000, "R5");

        // R9: write to the level address is ignored
        drive_src(9, 1'b1);
        wr(16, 32'h0);
        expect_st(16, 32'h200, 3'b000, "R9");
        wr(14, 32'hFFFF_FFFF);
        expect_st(14, 32'h0, 3'b000, "R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule